// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits after a floating-point execution unit. Each valid instruction hands it the exception bits that the operation raised. The block then decides whether an arithmetic trap must be taken. It folds the exceptions into a sticky status register that software can read, and it drops the exception classes that the instruction's ignore mask names. When a trap is needed, it produces a summary word and a one-hot mask that selects the destination register.

Two completion disciplines are supported. In the plain discipline, every raised bit is recorded as sticky status. Only after that is the ignore mask applied, and any bit that is left traps no matter what the enable mask says. In the software-completion discipline, ignored bits are removed before they reach the status. The bits that remain are then filtered by the trap-enable mask. A user-mode context in this discipline traps only when an enabled bit survives the filter. A system-mode context traps for any surviving non-ignored bit, and it also sets a marker bit in the summary word.

All results are registered and appear on the clock edge that follows the valid instruction. A clear input empties the sticky status.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, the status is 0, the trap strobe is low, and the summary and register mask are 0.
- R2: The exception vector has these bit positions: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. In the plain discipline (swc_mode=0), every raised bit is ORed into the sticky status, ignored bits included, and the status keeps its bits across instructions.
- R3: In the plain discipline, a trap is raised exactly when some raised bit is not ignored, whatever the enable mask holds. The summary word carries the completion marker at bit 0 and the exception classes at bits 6:1 (class k at bit k+1). For a plain trap the marker is 0 and the class bits equal the non-ignored raised bits.
- R4: In the software-completion discipline (swc_mode=1), only raised bits that are not ignored are ORed into the status.
- R5: In the software-completion discipline with user_mode=1, a trap is raised only if some non-ignored bit is also enabled. The summary then holds the enabled non-ignored bits at bits 6:1 and 1 at bit 0.
- R6: In the software-completion discipline with user_mode=0, any non-ignored raised bit traps, even when none is enabled. The summary holds the enabled non-ignored bits (possibly none) at bits 6:1 and 1 at bit 0.
- R7: A valid instruction whose exception vector is 0 leaves the status unchanged and raises no trap.
- R8: In a trap cycle, the register mask equals 1 shifted left by the destination register number. In any cycle without a trap, the register mask and the summary are 0.
- R9: The trap strobe, summary and mask appear on the cycle after the valid instruction and last one cycle, unless the next instruction traps again.
- R10: status_clr empties the sticky status on the next edge. The bits to be recorded from a valid instruction in that same cycle still land in the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction's exceptions are presented |
| exc_raw | input | 6 | Raw exception vector |
| exc_ignore | input | 6 | Per-instruction ignore mask |
| trap_enable | input | 6 | Trap-enable mask (software completion only) |
| swc_mode | input | 1 | 1 selects the software-completion discipline |
| user_mode | input | 1 | 1 for a user-mode context |
| dest_reg | input | REG_AW (5) | Destination register number |
| status_clr | input | 1 | Clears the sticky status |
| sticky_status | output | 6 | Accumulated exception status |
| trap_pulse | output | 1 | One-cycle trap strobe |
| trap_summary | output | 7 | Completion marker at bit 0, exception classes at bits 6:1 |
| trap_reg_mask | output | NUM_REGS (32) | One-hot destination mask |

## Verification
The bench targets the ordering difference between the two disciplines. An ignored bit must reach the status in plain mode and stay out of it in software-completion mode; a design that applied one order to both modes would show the wrong status. It also contrasts user and system contexts with nothing enabled: a design that ignored user_mode would either trap in user mode or stay silent in system mode. Further cases cover a zero exception vector on top of live status, which must neither trap nor change anything, and the top register number, where a narrow decoder would drop the mask bit. A clear that arrives together with a new instruction is also tested; a design that gave the clear priority would lose the new bits.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W = 6;
  localparam int SUM_W = EXC_W + 1;
  typedef logic [EXC_W-1:0] exc_vec_t;
  typedef logic [SUM_W-1:0] sum_vec_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
(
  input  exc_vec_t raw,
  input  exc_vec_t ign,
  input  exc_vec_t en,
  input  logic     swc,
  input  logic     user,
  output exc_vec_t record_bits,
  output logic     take_trap,
  output exc_vec_t sum_bits
);
  exc_vec_t kept;
  exc_vec_t kept_en;

  always_comb begin
    kept    = raw & ~ign;
    kept_en = kept & en;
    if (swc) begin
      // ignore applied before recording, then enable filter
      record_bits = kept;
      sum_bits    = kept_en;
      take_trap   = (kept != '0) && (!user || (kept_en != '0));
    end else begin
      // record everything, then drop ignored bits; enables unused
      record_bits = raw;
      sum_bits    = kept;
      take_trap   = (kept != '0);
    end
  end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky
  import fpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  exc_vec_t set_bits,
  output exc_vec_t status
);
  exc_vec_t status_q;
  logic     armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      status_q <= (clr ? '0 : status_q) | set_bits;
      armed_q  <= 1'b1;
    end
  end

  assign status = status_q;

  // R2
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !clr) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (status_q == '0));
endmodule

// File: rtl/fpx_trap_out.sv
module fpx_trap_out
  import fpx_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_AW   = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  exc_vec_t          exc_bits,
  input  logic              swc_mark,
  input  logic [REG_AW-1:0] dest,
  output logic              trap_q,
  output sum_vec_t          summary_q,
  output logic [NUM_REGS-1:0] mask_q
);
  logic [NUM_REGS-1:0] dec;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_dec
      assign dec[g] = (dest == REG_AW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q    <= 1'b0;
      summary_q <= '0;
      mask_q    <= '0;
    end else begin
      trap_q    <= fire;
      summary_q <= fire ? {exc_bits, swc_mark} : '0;
      mask_q    <= fire ? dec : '0;
    end
  end

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_q |-> (summary_q == '0 && mask_q == '0));

  // R8
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ($countones(mask_q) == 1));
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_AW   = $clog2(NUM_REGS)
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [5:0]          exc_raw,
  input  logic [5:0]          exc_ignore,
  input  logic [5:0]          trap_enable,
  input  logic                swc_mode,
  input  logic                user_mode,
  input  logic [REG_AW-1:0]   dest_reg,
  input  logic                status_clr,
  output logic [5:0]          sticky_status,
  output logic                trap_pulse,
  output logic [6:0]          trap_summary,
  output logic [NUM_REGS-1:0] trap_reg_mask
);
  exc_vec_t rec_bits;
  exc_vec_t sum_bits;
  logic     take;
  logic     live;
  exc_vec_t set_bits;

  assign live     = instr_valid && (exc_raw != '0);
  assign set_bits = live ? rec_bits : '0;

  fpx_classify u_cls (
    .raw        (exc_raw),
    .ign        (exc_ignore),
    .en         (trap_enable),
    .swc        (swc_mode),
    .user       (user_mode),
    .record_bits(rec_bits),
    .take_trap  (take),
    .sum_bits   (sum_bits)
  );

  fpx_sticky u_sticky (
    .clk     (clk),
    .rst     (rst),
    .clr     (status_clr),
    .set_bits(set_bits),
    .status  (sticky_status)
  );

  fpx_trap_out #(.NUM_REGS(NUM_REGS), .REG_AW(REG_AW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (live && take),
    .exc_bits (sum_bits),
    .swc_mark (swc_mode),
    .dest     (dest_reg),
    .trap_q   (trap_pulse),
    .summary_q(trap_summary),
    .mask_q   (trap_reg_mask)
  );

  // R5
  user_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && swc_mode && user_mode &&
     ((exc_raw & ~exc_ignore & trap_enable) == '0)) |=> !trap_pulse);

  // R7
  zero_vec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && exc_raw == '0 && !status_clr) |=>
      (!trap_pulse && sticky_status == $past(sticky_status)));

  // R9
  no_valid_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !trap_pulse);

  // R4
  swc_ignored_out_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && swc_mode && status_clr) |=>
      ((sticky_status & $past(exc_ignore & ~exc_raw)) == '0) &&
      ((sticky_status & $past(exc_ignore)) == '0));

  // R3
  plain_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !swc_mode) |=> !trap_summary[0]);
endmodule

// File: tb/tb_fpx_trap_ctrl.sv
module tb_fpx_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int AW = 5;
  localparam int NV = 9;

  // {swc, user, raw, ign, en, dest, exp_trap, exp_sum, exp_status}
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b0,6'h14,6'h10,6'h00,5'd3 ,1'b1,7'h08,6'h14}, // R2 R3 ignored still recorded
    {1'b0,1'b0,6'h10,6'h10,6'h3f,5'd7 ,1'b0,7'h00,6'h10}, // R3 all ignored
    {1'b1,1'b1,6'h11,6'h10,6'h01,5'd1 ,1'b1,7'h03,6'h01}, // R4 R5
    {1'b1,1'b1,6'h05,6'h00,6'h02,5'd4 ,1'b0,7'h00,6'h05}, // R5 none enabled
    {1'b1,1'b0,6'h05,6'h00,6'h02,5'd31,1'b1,7'h01,6'h05}, // R6 R8 top reg
    {1'b1,1'b0,6'h10,6'h10,6'h3f,5'd2 ,1'b0,7'h00,6'h00}, // R4 R6 all ignored
    {1'b0,1'b0,6'h3f,6'h00,6'h00,5'd0 ,1'b1,7'h7e,6'h3f}, // R3 all classes
    {1'b1,1'b1,6'h28,6'h08,6'h20,5'd9 ,1'b1,7'h41,6'h20}, // R5 int overflow
    {1'b0,1'b0,6'h00,6'h00,6'h3f,5'd5 ,1'b0,7'h00,6'h00}  // R7 zero vector
  };

  logic clk = 1'b0;
  logic rst, vld, swc, usr, clr;
  logic [5:0] raw, ign, en;
  logic [AW-1:0] dst;
  logic [5:0] st;
  logic tp;
  logic [6:0] sm;
  logic [NR-1:0] rm;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_trap_ctrl #(.NUM_REGS(NR), .REG_AW(AW)) dut (
    .clk(clk), .rst(rst), .instr_valid(vld), .exc_raw(raw), .exc_ignore(ign),
    .trap_enable(en), .swc_mode(swc), .user_mode(usr), .dest_reg(dst),
    .status_clr(clr), .sticky_status(st), .trap_pulse(tp),
    .trap_summary(sm), .trap_reg_mask(rm)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic s, input logic u, input logic [5:0] r,
                       input logic [5:0] i, input logic [5:0] e, input logic [AW-1:0] d);
    vld = 1'b1; swc = s; usr = u; raw = r; ign = i; en = e; dst = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; vld = 1'b0; swc = 1'b0; usr = 1'b0; clr = 1'b0;
    raw = '0; ign = '0; en = '0; dst = '0;
    @(negedge clk);
    tick();
    check("R1 status", st, 0);
    check("R1 trap", tp, 0);
    check("R1 summary", sm, 0);
    check("R1 mask", rm, 0);
    rst = 1'b0;
    tick();
    check("R1 idle after reset", {st, tp, sm}, 0);

    for (int k = 0; k < NV; k++) begin
      clr = 1'b1; vld = 1'b0;
      tick();
      clr = 1'b0;
      issue(VEC[k][38], VEC[k][37], VEC[k][36:31], VEC[k][30:25],
            VEC[k][24:19], VEC[k][18:14]);
      tick();
      vld = 1'b0;
      check($sformatf("R3/R5/R6 vec%0d trap", k), tp, VEC[k][13]);
      check($sformatf("R3/R5/R6 vec%0d summary", k), sm, VEC[k][12:6]);
      check($sformatf("R2/R4 vec%0d status", k), st, VEC[k][5:0]);
      check($sformatf("R8 vec%0d mask", k), rm,
            VEC[k][13] ? (64'd1 << VEC[k][18:14]) : 64'd0);
    end

    // R2 accumulation across instructions without clear
    clr = 1'b1; tick(); clr = 1'b0;
    issue(1'b0, 1'b0, 6'h01, 6'h00, 6'h00, 5'd2); tick();
    issue(1'b0, 1'b0, 6'h02, 6'h02, 6'h00, 5'd2); tick();
    vld = 1'b0;
    check("R2 sticky accumulation", st, 6'h03);
    check("R3 fully ignored no trap", tp, 0);

    // R7 zero vector on live status
    issue(1'b1, 1'b0, 6'h00, 6'h00, 6'h3f, 5'd6); tick();
    vld = 1'b0;
    check("R7 status unchanged", st, 6'h03);
    check("R7 no trap", tp, 0);

    // R10 clear with simultaneous instruction
    clr = 1'b1;
    issue(1'b0, 1'b0, 6'h04, 6'h00, 6'h00, 5'd8); tick();
    clr = 1'b0; vld = 1'b0;
    check("R10 clear keeps new bits", st, 6'h04);
    check("R10 trap", tp, 1);
    clr = 1'b1; tick(); clr = 1'b0;
    check("R10 clear alone", st, 6'h00);

    // R9 back-to-back traps then a single-cycle drop
    issue(1'b0, 1'b0, 6'h01, 6'h00, 6'h00, 5'd10); tick();
    check("R9 first trap", tp, 1);
    check("R8 first mask", rm, 32'h0000_0400);
    issue(1'b0, 1'b0, 6'h02, 6'h00, 6'h00, 5'd11); tick();
    vld = 1'b0;
    check("R9 second trap", tp, 1);
    check("R8 second mask", rm, 32'h0000_0800);
    tick();
    check("R9 strobe ends", tp, 0);
    check("R8 mask cleared", rm, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule